// File: doc/BRIEF.md
# Sum-of-Products Logic Block with Output Macrocells

The block computes a set of programmable logic functions in sum-of-products form. Each output has a bank of product terms. Every product term is an AND of literals picked by configuration bits, and a literal is either a dedicated input or a fed-back macrocell value, in true or complemented form. Each output OR-gates only its own fixed bank of terms. A per-output macrocell then optionally inverts the sum. It presents either that combinational value or a clocked copy of it, and it decides whether the pad is driven.

A macrocell whose driver is switched off turns its pad into an extra input, and the pad level is what the product terms see for that literal. A driven macrocell feeds its presented value back to the product terms, so functions can be built over several levels and small state machines can be built from registered macrocells. Configuration is loaded one macrocell at a time through a parallel write port. Each configuration word holds that macrocell's three control bits and all of its product-term rows.

Top module: `pal_block`

## Requirements
- R1: While `rst` is high at a rising edge, every configuration word and every macrocell flip-flop is cleared. After reset all `pin_oe` bits are 0 and all `pin_out` bits are 0.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` replaces the word of macrocell `cfg_addr`, and it takes effect from the next cycle. Word layout: bit 0 invert, bit 1 registered select, bit 2 driver enable, then product term t in bits 3+t*2S .. 2+(t+1)*2S, where S = N_IN+N_MC. Within a term, signal k uses bit 2k for its true literal and bit 2k+1 for its complement. Signal k < N_IN is `in_i[k]`, and signal N_IN+j is the feedback of macrocell j.
- R3: A product term is 1 exactly when every literal selected in its row is 1. A row with no bits set gives 0, and so does a row holding both literals of one signal.
- R4: The sum of macrocell i is the OR of its own N_PT product terms only.
- R5: The macrocell function equals the sum XORed with the invert bit.
- R6: With the driver enabled and registered select 0, `pin_oe` is 1 and `pin_out` shows the function in the same cycle.
- R7: Each macrocell flip-flop loads its function at every rising edge and clears to 0 when `rst` is high. With the driver enabled and registered select 1, `pin_out` shows the flip-flop.
- R8: With the driver disabled, `pin_oe` is 0, `pin_out` carries the combinational function, and the macrocell's feedback literal is `pin_in` of that macrocell.
- R9: A registered, driven macrocell feeds back its flip-flop value, so a term using its own complement makes it toggle every cycle.
- R10: The combinational feedback of a driven macrocell j is visible to macrocells with a higher index. Macrocells with index j or lower read that literal as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_MC) (2) | Macrocell index to write |
| cfg_wdata | input | 3+N_PT*2*(N_IN+N_MC) (103) | Configuration word |
| in_i | input | N_IN (6) | Dedicated logic inputs |
| pin_in | input | N_MC (4) | Level seen on each macrocell pad |
| pin_out | output | N_MC (4) | Value each macrocell presents to its pad |
| pin_oe | output | N_MC (4) | Pad driver enable per macrocell |

## Verification
The hardest situation to reach is a chain of feedback that mixes all three macrocell modes. One example is a pad-input macrocell feeding a combinational macrocell, which in turn feeds a higher-indexed one, while a registered macrocell feeds back its own state. Random configuration words are kept sparse so that product terms actually fire, and they are rewritten often during random input and pad traffic. This lets the modes overlap in many combinations. Directed sequences build the specific chains: a pad input read through feedback, forward and backward combinational feedback, and a self-toggling register. A reference model that walks the macrocells in index order predicts `pin_out` and `pin_oe` for every cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int CTL_W = 3;

    // Control bits sit at the bottom of every configuration word.
    typedef struct packed {
        logic oe;
        logic reg_sel;
        logic invert;
    } mc_ctl_t;

    typedef enum logic [1:0] {
        MODE_INPUT = 2'd0,
        MODE_COMB  = 2'd1,
        MODE_REG   = 2'd2
    } mc_mode_t;

    function automatic mc_mode_t decode_mode(input mc_ctl_t c);
        if (!c.oe)
            return MODE_INPUT;
        else if (c.reg_sel)
            return MODE_REG;
        else
            return MODE_COMB;
    endfunction

    // Literal pair for one signal: bit 0 true form, bit 1 complement.
    function automatic logic [1:0] lit_pair(input logic x);
        return {~x, x};
    endfunction

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
    parameter int N_MC   = 4,
    parameter int WORD_W = 103,
    localparam int ADDR_W = (N_MC > 1) ? $clog2(N_MC) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [N_MC-1:0][WORD_W-1:0]   words
);

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (we && (int'(addr) < N_MC)) begin
            words[addr] <= wdata;
        end
    end

    // R2: a write lands in the addressed word one edge later
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(addr) < N_MC)) |=> (words[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/pal_sum.sv
module pal_sum #(
    parameter int N_SIG = 10,
    parameter int N_PT  = 5,
    localparam int LIT_W = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]      sig,
    input  logic [N_PT*LIT_W-1:0] rows,
    output logic                  sum
);
    import pal_pkg::*;

    logic [LIT_W-1:0] lits;
    logic [N_PT-1:0]  hit;

    always_comb begin
        for (int k = 0; k < N_SIG; k++) begin
            lits[2*k +: 2] = lit_pair(sig[k]);
        end
    end

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        logic [LIT_W-1:0] row;
        assign row    = rows[t*LIT_W +: LIT_W];
        assign hit[t] = (row != '0) && ((row & ~lits) == '0);
    end

    assign sum = |hit;

    // R3: a bank with no programmed literal can never raise the sum
    always_comb begin
        if (rows == '0) begin
            p_empty_rows_r3: assert (sum == 1'b0);
        end
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mc_ctl_t ctl,
    input  logic    sum,
    output logic    f,
    output logic    q,
    output logic    sel_val
);

    mc_mode_t mode;

    assign mode = decode_mode(ctl);
    assign f    = sum ^ ctl.invert;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= f;
    end

    always_comb begin
        case (mode)
            MODE_REG: sel_val = q;
            default:  sel_val = f;
        endcase
    end

    // R7: flip-flop clears on reset and otherwise follows the function
    p_reg_clear_r7: assert property (@(posedge clk)
        rst |=> (q == 1'b0));
    p_reg_capture_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(f)));

    // R5: with no term active the function equals the invert bit
    always_comb begin
        if (!sum) begin
            p_polarity_r5: assert (f == ctl.invert);
        end
    end

endmodule

// File: rtl/pal_block.sv
module pal_block
    import pal_pkg::*;
#(
    parameter int N_IN = 6,
    parameter int N_MC = 4,
    parameter int N_PT = 5,
    localparam int N_SIG  = N_IN + N_MC,
    localparam int LIT_W  = 2 * N_SIG,
    localparam int ROW_W  = N_PT * LIT_W,
    localparam int WORD_W = CTL_W + ROW_W,
    localparam int ADDR_W = (N_MC > 1) ? $clog2(N_MC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   in_i,
    input  logic [N_MC-1:0]   pin_in,
    output logic [N_MC-1:0]   pin_out,
    output logic [N_MC-1:0]   pin_oe
);

    logic [N_MC-1:0][WORD_W-1:0] words;
    mc_ctl_t [N_MC-1:0]          ctl;
    logic [N_MC-1:0]             q_all;
    logic [N_MC-1:0]             fb_base;
    logic [N_MC-1:0]             comb_mode;

    pal_cfg_store #(
        .N_MC   (N_MC),
        .WORD_W (WORD_W)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .words (words)
    );

    // Feedback that never depends on a combinational result: pad levels
    // for input-mode macrocells, stored state for registered ones.
    always_comb begin
        for (int j = 0; j < N_MC; j++) begin
            ctl[j] = mc_ctl_t'(words[j][CTL_W-1:0]);
            case (decode_mode(ctl[j]))
                MODE_INPUT: fb_base[j] = pin_in[j];
                MODE_REG:   fb_base[j] = q_all[j];
                default:    fb_base[j] = 1'b0;
            endcase
            comb_mode[j] = (decode_mode(ctl[j]) == MODE_COMB);
        end
    end

    for (genvar i = 0; i < N_MC; i++) begin : g_mc
        logic [N_MC-1:0]  seen;
        logic [N_SIG-1:0] sig;
        logic             sum;
        logic             f;
        logic             q;
        logic             sel_val;

        // Combinational feedback ripples upward in index order only.
        if (i == 0) begin : g_first
            assign seen = fb_base;
        end else begin : g_next
            always_comb begin
                seen = g_mc[i-1].seen;
                if (comb_mode[i-1])
                    seen[i-1] = g_mc[i-1].f;
            end
        end

        assign sig = {seen, in_i};

        pal_sum #(
            .N_SIG (N_SIG),
            .N_PT  (N_PT)
        ) u_sum (
            .sig  (sig),
            .rows (words[i][WORD_W-1:CTL_W]),
            .sum  (sum)
        );

        pal_macrocell u_mc (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[i]),
            .sum     (sum),
            .f       (f),
            .q       (q),
            .sel_val (sel_val)
        );

        assign q_all[i]   = q;
        assign pin_out[i] = sel_val;
        assign pin_oe[i]  = ctl[i].oe;

        // R8: an undriven pad is what the product terms read for it
        always_comb begin
            if (!pin_oe[i]) begin
                p_pin_input_r8: assert (seen[i] == pin_in[i]);
            end
        end
    end

endmodule

// File: tb/pal_block_tb_top.sv
`timescale 1ns/1ps
module pal_block_tb_top;

    localparam int N_IN   = 6;
    localparam int N_MC   = 4;
    localparam int N_PT   = 5;
    localparam int N_SIG  = N_IN + N_MC;
    localparam int LIT_W  = 2 * N_SIG;
    localparam int ROW_W  = N_PT * LIT_W;
    localparam int CTL_W  = 3;
    localparam int WORD_W = CTL_W + ROW_W;
    localparam int ADDR_W = $clog2(N_MC);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [WORD_W-1:0] cfg_wdata = '0;
    logic [N_IN-1:0]   in_i = '0;
    logic [N_MC-1:0]   pin_in = '0;
    logic [N_MC-1:0]   pin_out;
    logic [N_MC-1:0]   pin_oe;

    pal_block #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_i(in_i), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #10 clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference state
    logic [WORD_W-1:0] mcfg [N_MC];
    logic [N_MC-1:0]   mq;
    logic [N_MC-1:0]   exp_out, exp_oe, exp_f;

    function automatic void model_eval(input logic [N_IN-1:0] iv, input logic [N_MC-1:0] pv);
        logic [N_MC-1:0] fcur;
        fcur = '0;
        for (int i = 0; i < N_MC; i++) begin
            logic [N_MC-1:0]  sn;
            logic [N_SIG-1:0] sg;
            logic [LIT_W-1:0] row;
            logic             s;
            logic             ok;
            for (int j = 0; j < N_MC; j++) begin
                if (!mcfg[j][2])      sn[j] = pv[j];
                else if (mcfg[j][1])  sn[j] = mq[j];
                else if (j < i)       sn[j] = fcur[j];
                else                  sn[j] = 1'b0;
            end
            sg = {sn, iv};
            s  = 1'b0;
            for (int t = 0; t < N_PT; t++) begin
                row = mcfg[i][CTL_W + t*LIT_W +: LIT_W];
                ok  = (row != '0);
                for (int k = 0; k < N_SIG; k++) begin
                    if (row[2*k] && !sg[k])   ok = 1'b0;
                    if (row[2*k+1] && sg[k])  ok = 1'b0;
                end
                if (ok) s = 1'b1;
            end
            fcur[i]    = s ^ mcfg[i][0];
            exp_oe[i]  = mcfg[i][2];
            exp_out[i] = (mcfg[i][2] && mcfg[i][1]) ? mq[i] : fcur[i];
        end
        exp_f = fcur;
    endfunction

    task automatic check(input string tag, input string what, input logic [N_MC-1:0] act, input logic [N_MC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [N_IN-1:0] iv, input logic [N_MC-1:0] pv,
                        input logic we, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        logic [N_MC-1:0] nf;
        logic            r;
        @(negedge clk);
        in_i = iv; pin_in = pv; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        #1;
        model_eval(iv, pv);
        check(tag, "pin_oe", pin_oe, exp_oe);
        check(tag, "pin_out", pin_out, exp_out);
        nf = exp_f;
        r  = rst;
        @(posedge clk);
        #1;
        if (r) begin
            mq = '0;
            for (int j = 0; j < N_MC; j++) mcfg[j] = '0;
        end else begin
            mq = nf;
            if (we) mcfg[a] = d;
        end
        cfg_we = 1'b0;
    endtask

    function automatic logic [WORD_W-1:0] mk(input logic oe, input logic rs, input logic inv);
        logic [WORD_W-1:0] w;
        w = '0;
        w[2] = oe; w[1] = rs; w[0] = inv;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] lit(input logic [WORD_W-1:0] w, input int t, input int k, input logic comp);
        logic [WORD_W-1:0] r;
        r = w;
        r[CTL_W + t*LIT_W + 2*k + int'(comp)] = 1'b1;
        return r;
    endfunction

    task automatic wr(input string tag, input int a, input logic [WORD_W-1:0] d);
        step(tag, in_i, pin_in, 1'b1, ADDR_W'(a), d);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20.0 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        mq = '0;
        for (int j = 0; j < N_MC; j++) mcfg[j] = '0;

        // R1: reset state
        rst = 1'b1;
        repeat (3) step("R1", '0, '0, 1'b0, '0, '0);
        rst = 1'b0;
        step("R1", 6'h3f, 4'hf, 1'b0, '0, '0);

        // R4 R6: macrocell 0 combinational, last term = in1
        wr("R2", 0, lit(mk(1, 0, 0), N_PT-1, 1, 1'b0));
        foreach (in_i[b]) step("R4 R6", 6'(1 << b), '0, 1'b0, '0, '0);
        step("R4 R6", 6'h3d, '0, 1'b0, '0, '0);

        // R3: contradictory row, then polarity (R5)
        wr("R2", 1, lit(lit(mk(1, 0, 0), 0, 0, 1'b0), 0, 0, 1'b1));
        step("R3", 6'h01, '0, 1'b0, '0, '0);
        step("R3", 6'h00, '0, 1'b0, '0, '0);
        wr("R2", 1, mk(1, 0, 1));
        step("R3 R5", 6'h15, '0, 1'b0, '0, '0);
        wr("R2", 1, lit(mk(1, 0, 1), 2, 0, 1'b0));
        step("R5", 6'h01, '0, 1'b0, '0, '0);
        step("R5", 6'h00, '0, 1'b0, '0, '0);

        // R8: macrocell 2 as pad input, macrocell 3 reads it
        wr("R2", 2, mk(0, 1, 0));
        wr("R2", 3, lit(mk(1, 0, 0), 0, N_IN+2, 1'b0));
        step("R8", '0, 4'b0100, 1'b0, '0, '0);
        step("R8", '0, 4'b1011, 1'b0, '0, '0);
        step("R8", '0, 4'b0100, 1'b0, '0, '0);

        // R10: macrocell 1 = in0; 3 reads it forward, 0 reads it backward
        wr("R2", 1, lit(mk(1, 0, 0), 0, 0, 1'b0));
        wr("R2", 3, lit(mk(1, 0, 0), 1, N_IN+1, 1'b0));
        wr("R2", 0, lit(mk(1, 0, 0), 0, N_IN+1, 1'b1));
        step("R10", 6'h01, '0, 1'b0, '0, '0);
        step("R10", 6'h00, '0, 1'b0, '0, '0);
        step("R10", 6'h01, '0, 1'b0, '0, '0);

        // R9 R7: self-toggling registered macrocell 0
        wr("R2", 0, lit(mk(1, 1, 0), 0, N_IN+0, 1'b1));
        repeat (5) step("R9 R7", '0, '0, 1'b0, '0, '0);

        // R7 R1: synchronous reset in mid-run
        rst = 1'b1;
        step("R7", '0, '0, 1'b0, '0, '0);
        rst = 1'b0;
        step("R1 R7", '0, '0, 1'b0, '0, '0);
        wr("R2", 0, mk(1, 1, 0));
        step("R7", '0, '0, 1'b0, '0, '0);

        // Random traffic with sparse configuration words
        for (int n = 0; n < 3000; n++) begin
            logic [WORD_W-1:0] w;
            logic              we;
            we = ($urandom_range(5) == 0);
            w  = '0;
            if (we) begin
                w[2:0] = 3'($urandom_range(7));
                for (int b = CTL_W; b < WORD_W; b++)
                    w[b] = ($urandom_range(11) == 0);
            end
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10", 6'($urandom), 4'($urandom), we,
                 ADDR_W'($urandom_range(N_MC-1)), w);
        end

        summary();
    end

endmodule